// File: doc/BRIEF.md
# Framed Command Packet Receiver

This block sits behind the byte-level engine of an I2C slave and turns the stream of received bytes into framed command packets. A frame opens with the marker byte 0x01. Next comes a 16-bit length, most significant byte first, which counts the command byte, the data bytes and the trailing checksum byte. After that the body follows: the command byte, the data bytes and then the checksum. The checksum is the modulo-256 sum of the command byte and the data bytes. The receiver stores the body in a parameterised buffer, checks the checksum and decodes the command. It then raises a one-cycle frame strobe carrying one of four results: START, WRITE, END or ERROR. The data bytes stay readable through an index port until the next frame begins.

Flow control works one byte at a time. After every accepted byte except the last byte of a frame, the receiver pulses a release so that the byte engine stops stretching the clock. After the last byte it keeps the bus held. The consumer (for example a flash programming sequencer) handles the command and then releases the bus. A matching address phase with the write direction is released the same way. A matching address phase with the read direction is a protocol error. It lights both indicator outputs and holds the bus until reset. A stop condition in the middle of a frame drops the partial frame.

Top module: `cmd_frame_rx`

## Requirements
- R1: After reset, frameValid, relPulse, busHold and both ledOn bits are 0.
- R2: cmdCode uses 0 for START, 1 for WRITE, 2 for END and 3 for ERROR. The frame 0x01, 0x00, 0x02, 0x02, 0x02 gives a frameValid pulse with cmdCode 0 and payloadLen 0. The pulse comes one cycle after the checksum byte.
- R3: A WRITE frame (command 0x03) with N data bytes gives cmdCode 1 and payloadLen N. Index i on rdIdx returns data byte i, counting from 0, on rdData in the same cycle.
- R4: The checksum is the sum of the command byte and the data bytes, modulo 256, with carries dropped. A final byte that differs from this sum gives cmdCode 3.
- R5: A command byte other than 0x02, 0x03 or 0x04 gives cmdCode 3, even when the checksum is correct.
- R6: In the idle state, any first byte other than 0x01 produces a frameValid pulse with cmdCode 3 on the next cycle, and busHold is set.
- R7: A length below 2, or above the buffer depth DEPTH, produces a frameValid pulse with cmdCode 3 one cycle after the second length byte. Nothing is written to the buffer, and the receiver returns to idle.
- R8: relPulse is high for one cycle after each accepted byte that is not the last of a frame. After the last byte, busHold stays 1 and relPulse stays 0 until hostRelease is raised. The cycle after hostRelease, relPulse is 1 and busHold is 0.
- R9: An address phase whose upper seven bits match SLAVE_ADDR (0xA0) and whose bit 0 is 0 (write) gives a relPulse. A non-matching address is ignored. Bit 0 equal to 1 (read) sets ledOn to 2'b11 and holds busHold at 1 until reset. While that holds, bytes and hostRelease have no effect.
- R10: stopSeen in the middle of a frame returns the receiver to idle. No frame is reported, and the next 0x01 starts a new frame.
- R11: The frame 0x01, 0x00, 0x02, 0x04, 0x04 gives cmdCode 2 (END).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byteValid | input | 1 | A received data byte is present this cycle |
| byteData | input | 8 | Received data byte |
| addrValid | input | 1 | An address phase byte is present this cycle |
| addrByte | input | 8 | Address byte: 7-bit address in [7:1], direction in [0] (1 = read) |
| stopSeen | input | 1 | A stop condition was detected on the bus |
| hostRelease | input | 1 | Consumer releases a bus hold after a frame result |
| rdIdx | input | $clog2(DEPTH) | Index of the data byte to read |
| rdData | output | 8 | Data byte selected by rdIdx |
| frameValid | output | 1 | One-cycle strobe: a frame result is available |
| cmdCode | output | 2 | Frame result: 0 START, 1 WRITE, 2 END, 3 ERROR |
| payloadLen | output | 16 | Number of data bytes in the last frame (length minus 2) |
| relPulse | output | 1 | One-cycle pulse that ends clock stretching |
| busHold | output | 1 | Bus is held by the receiver |
| ledOn | output | 2 | Both bits set on a read-direction address error |

## Verification
A wrong receive state shows up at the byte that follows it. If the state machine is in the wrong state or the length phase is misplaced, a later byte is read as the wrong field. The next frame then reports the wrong command or an ERROR on the strobe cycle. A wrong count or a bad limit test changes which byte is taken as final. That shows within one cycle, as a relPulse where a hold was expected or the reverse, or as a strobe that fires early or late. The directed frames cover these cases: checksums that wrap past 255, lengths out of range, aborts in the middle of a frame, and the sticky direction error.

// File: rtl/frx_pkg.sv
package frx_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_END   = 2'd2,
    CMD_ERROR = 2'd3
  } cmd_e;

  // strobes from the control path to the datapath
  typedef struct packed {
    logic clear;     // new frame: zero the running sum
    logic store;     // write byteData into the body buffer
    logic lastByte;  // the stored byte is the checksum
    logic forceErr;  // framing error: report ERROR now
  } ctl_strobe_t;

  localparam logic [7:0] SOF_CODE = 8'h01;
  localparam logic [7:0] OP_START = 8'h02;
  localparam logic [7:0] OP_WRITE = 8'h03;
  localparam logic [7:0] OP_END   = 8'h04;

endpackage

// File: rtl/frx_ctrl.sv
module frx_ctrl
  import frx_pkg::*;
#(
  parameter int          DEPTH      = 16,
  parameter int          IDX_W      = 4,
  parameter logic [7:0]  SLAVE_ADDR = 8'hA0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic             addrValid,
  input  logic [7:0]       addrByte,
  input  logic             stopSeen,
  input  logic             hostRelease,
  output ctl_strobe_t      strb,
  output logic [IDX_W-1:0] idx,
  output logic [15:0]      payloadLen,
  output logic             relPulse,
  output logic             busHold,
  output logic [1:0]       ledOn
);

  localparam logic [15:0] DEPTH16 = 16'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_SOF, S_LEN} st_e;

  st_e              state;
  logic             lenPhase;
  logic [7:0]       lenHi;
  logic [15:0]      lenReg;
  logic [IDX_W-1:0] cnt;
  logic             held;
  logic             dirErr;
  logic             relQ;
  logic             finalByte;

  logic        accByte, addrHit, addrWrite, lenBad, lastBody;
  logic [15:0] lenNow;

  assign accByte   = byteValid && !held && !dirErr && !stopSeen;
  assign addrHit   = addrValid && !held && !dirErr && (addrByte[7:1] == SLAVE_ADDR[7:1]);
  assign addrWrite = addrHit && !addrByte[0];
  assign lenNow    = {lenHi, byteData};
  assign lenBad    = (lenNow < 16'd2) || (lenNow > DEPTH16);
  assign lastBody  = ({{(16-IDX_W){1'b0}}, cnt} == (lenReg - 16'd1));

  always_comb begin
    strb      = '0;
    finalByte = 1'b0;
    if (accByte) begin
      unique case (state)
        S_IDLE: begin
          if (byteData != SOF_CODE) begin
            strb.forceErr = 1'b1;
            finalByte     = 1'b1;
          end else begin
            strb.clear = 1'b1;
          end
        end
        S_SOF: begin
          if (lenPhase && lenBad) begin
            strb.forceErr = 1'b1;
            finalByte     = 1'b1;
          end
        end
        default: begin
          strb.store = 1'b1;
          if (lastBody) begin
            strb.lastByte = 1'b1;
            finalByte     = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lenPhase <= 1'b0;
      lenHi    <= '0;
      lenReg   <= 16'd2;
      cnt      <= '0;
      held     <= 1'b0;
      dirErr   <= 1'b0;
      relQ     <= 1'b0;
    end else begin
      relQ <= (accByte && !finalByte) || addrWrite || (held && hostRelease);
      if (addrHit && addrByte[0]) dirErr <= 1'b1;
      if (accByte && finalByte)   held <= 1'b1;
      else if (hostRelease)       held <= 1'b0;

      if (stopSeen) begin
        state    <= S_IDLE;
        lenPhase <= 1'b0;
      end else if (accByte) begin
        unique case (state)
          S_IDLE: begin
            if (byteData == SOF_CODE) begin
              state    <= S_SOF;
              lenPhase <= 1'b0;
            end
          end
          S_SOF: begin
            if (!lenPhase) begin
              lenHi    <= byteData;
              lenPhase <= 1'b1;
            end else begin
              lenPhase <= 1'b0;
              if (lenBad) begin
                state <= S_IDLE;
              end else begin
                lenReg <= lenNow;
                cnt    <= '0;
                state  <= S_LEN;
              end
            end
          end
          default: begin
            if (lastBody) state <= S_IDLE;
            else          cnt   <= cnt + 1'b1;
          end
        endcase
      end
    end
  end

  assign idx        = cnt;
  assign payloadLen = lenReg - 16'd2;
  assign relPulse   = relQ;
  assign busHold    = held || dirErr;
  assign ledOn      = {dirErr, dirErr};

endmodule

// File: rtl/frx_data.sv
module frx_data
  import frx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       byteData,
  input  ctl_strobe_t      strb,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdData,
  output logic             frameValid,
  output logic [1:0]       cmdCode
);

  logic [7:0]       body [DEPTH];
  logic [7:0]       sum;
  logic [IDX_W-1:0] rdPtr;

  function automatic cmd_e decodeCmd(input logic [7:0] op, input logic sumOk);
    if (!sumOk) return CMD_ERROR;
    case (op)
      OP_START: return CMD_START;
      OP_WRITE: return CMD_WRITE;
      OP_END:   return CMD_END;
      default:  return CMD_ERROR;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (strb.store) body[idx] <= byteData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum        <= '0;
      frameValid <= 1'b0;
      cmdCode    <= CMD_ERROR;
    end else begin
      frameValid <= 1'b0;
      if (strb.clear) sum <= '0;
      else if (strb.store && !strb.lastByte) sum <= sum + byteData;

      if (strb.forceErr) begin
        frameValid <= 1'b1;
        cmdCode    <= CMD_ERROR;
      end else if (strb.store && strb.lastByte) begin
        frameValid <= 1'b1;
        cmdCode    <= decodeCmd(body[0], sum == byteData);
      end
    end
  end

  assign rdPtr  = rdIdx + IDX_W'(1);
  assign rdData = body[rdPtr];

endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
  parameter int         DEPTH      = 16,
  parameter logic [7:0] SLAVE_ADDR = 8'hA0,
  localparam int        IDX_W      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic             addrValid,
  input  logic [7:0]       addrByte,
  input  logic             stopSeen,
  input  logic             hostRelease,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdData,
  output logic             frameValid,
  output logic [1:0]       cmdCode,
  output logic [15:0]      payloadLen,
  output logic             relPulse,
  output logic             busHold,
  output logic [1:0]       ledOn
);

  frx_pkg::ctl_strobe_t strb;
  logic [IDX_W-1:0]     idx;

  frx_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .byteValid(byteValid), .byteData(byteData),
    .addrValid(addrValid), .addrByte(addrByte),
    .stopSeen(stopSeen), .hostRelease(hostRelease),
    .strb(strb), .idx(idx), .payloadLen(payloadLen),
    .relPulse(relPulse), .busHold(busHold), .ledOn(ledOn)
  );

  frx_data #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .byteData(byteData), .strb(strb), .idx(idx),
    .rdIdx(rdIdx), .rdData(rdData),
    .frameValid(frameValid), .cmdCode(cmdCode)
  );

endmodule

// File: rtl/frx_checker.sv
module frx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stopSeen,
  input logic       hostRelease,
  input logic       frameValid,
  input logic [1:0] cmdCode,
  input logic       relPulse,
  input logic       busHold,
  input logic [1:0] ledOn
);

  a_r8_hold_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frameValid |-> busHold);

  a_r8_no_release_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frameValid |-> !relPulse);

  a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busHold && hostRelease && ledOn == 2'b00) |=> (!busHold && relPulse));

  a_r8_quiet_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busHold && !hostRelease) |=> !relPulse);

  a_r9_dir_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (ledOn != 2'b00) |-> (ledOn == 2'b11 && busHold));

  a_r9_dir_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ledOn == 2'b11) |=> (ledOn == 2'b11));

  a_r10_stop_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    stopSeen |=> !frameValid);

  a_r2_code_known: assert property (@(posedge clk) disable iff (!rst_n)
    frameValid |-> !$isunknown(cmdCode));

endmodule

bind cmd_frame_rx frx_checker u_frx_checker (
  .clk(clk), .rst_n(rst_n), .stopSeen(stopSeen), .hostRelease(hostRelease),
  .frameValid(frameValid), .cmdCode(cmdCode), .relPulse(relPulse),
  .busHold(busHold), .ledOn(ledOn)
);

// File: tb/test_cmd_frame_rx.sv
`timescale 1ns/1ps
module test_cmd_frame_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        addrValid = 1'b0;
  logic [7:0]  addrByte = '0;
  logic        stopSeen = 1'b0;
  logic        hostRelease = 1'b0;
  logic [3:0]  rdIdx = '0;
  logic [7:0]  rdData;
  logic        frameValid;
  logic [1:0]  cmdCode;
  logic [15:0] payloadLen;
  logic        relPulse;
  logic        busHold;
  logic [1:0]  ledOn;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [7:0] dat [8];

  always #2.5 clk = ~clk;

  cmd_frame_rx i_cmd_frame_rx (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteData(byteData),
    .addrValid(addrValid), .addrByte(addrByte), .stopSeen(stopSeen),
    .hostRelease(hostRelease), .rdIdx(rdIdx), .rdData(rdData),
    .frameValid(frameValid), .cmdCode(cmdCode), .payloadLen(payloadLen),
    .relPulse(relPulse), .busHold(busHold), .ledOn(ledOn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  task automatic doReset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive one byte for one cycle; outputs sampled at the following negedge
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteData  = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic release_(input string tag);
    @(negedge clk) hostRelease = 1'b1;
    @(negedge clk) hostRelease = 1'b0;
    chk({tag, " relPulse after release"}, relPulse, 1);
    chk({tag, " busHold after release"}, busHold, 0);
  endtask

  // full frame; checks release after each non-final byte (R8)
  task automatic sendFrame(input logic [7:0] cmd, input int n, input logic [7:0] badAdj);
    logic [7:0]  s;
    logic [15:0] len;
    len = 16'(n + 2);
    s = cmd;
    for (int i = 0; i < n; i++) s = s + dat[i];
    sendByte(8'h01);    chk("R8 rel sof", relPulse, 1);
    sendByte(len[15:8]); chk("R8 rel lenHi", relPulse, 1);
    sendByte(len[7:0]);  chk("R8 rel lenLo", relPulse, 1);
    sendByte(cmd);       chk("R8 rel cmd", relPulse, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(dat[i]);
      chk("R8 rel data", relPulse, 1);
    end
    sendByte(s + badAdj);
    chk("R8 no rel on final", relPulse, 0);
    chk("R8 hold on final", busHold, 1);
    chk("R8 frameValid on final", frameValid, 1);
  endtask

  task automatic tReset();
    chk("R1 frameValid", frameValid, 0);
    chk("R1 relPulse", relPulse, 0);
    chk("R1 busHold", busHold, 0);
    chk("R1 ledOn", ledOn, 0);
  endtask

  task automatic tStart();
    sendFrame(8'h02, 0, 8'h00);
    chk("R2 START code", cmdCode, 0);
    chk("R2 START payloadLen", payloadLen, 0);
    @(negedge clk);
    chk("R2 strobe one cycle", frameValid, 0);
    chk("R8 still held", busHold, 1);
    chk("R8 no rel while held", relPulse, 0);
    release_("R8");
  endtask

  task automatic tWrite();
    dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33; dat[3] = 8'h44;
    sendFrame(8'h03, 4, 8'h00);
    chk("R3 WRITE code", cmdCode, 1);
    chk("R3 payloadLen", payloadLen, 4);
    for (int i = 0; i < 4; i++) begin
      rdIdx = 4'(i);
      #1;
      chk("R3 payload byte", rdData, dat[i]);
    end
    release_("R3");
  endtask

  task automatic tEnd();
    sendFrame(8'h04, 0, 8'h00);
    chk("R11 END code", cmdCode, 2);
    release_("R11");
  endtask

  task automatic tChecksum();
    dat[0] = 8'hFF; dat[1] = 8'hFF; dat[2] = 8'h10; dat[3] = 8'h20;
    sendFrame(8'h03, 4, 8'h00);     // sum wraps to 0x31
    chk("R4 wrapped checksum accepted", cmdCode, 1);
    release_("R4");
    sendFrame(8'h03, 4, 8'h01);
    chk("R4 bad checksum", cmdCode, 3);
    release_("R4");
  endtask

  task automatic tBadCmd();
    dat[0] = 8'h5A;
    sendFrame(8'h05, 1, 8'h00);
    chk("R5 unknown command", cmdCode, 3);
    release_("R5");
  endtask

  task automatic tBadSof();
    sendByte(8'h7E);
    chk("R6 frameValid", frameValid, 1);
    chk("R6 ERROR", cmdCode, 3);
    chk("R6 hold", busHold, 1);
    chk("R6 no rel", relPulse, 0);
    release_("R6");
  endtask

  task automatic tBadLen();
    sendByte(8'h01);
    sendByte(8'h01);
    chk("R7 no early frame", frameValid, 0);
    sendByte(8'h00);               // length 256 > depth
    chk("R7 long frameValid", frameValid, 1);
    chk("R7 long ERROR", cmdCode, 3);
    release_("R7");
    sendByte(8'h01);
    sendByte(8'h00);
    sendByte(8'h01);               // length 1 < 2
    chk("R7 short frameValid", frameValid, 1);
    chk("R7 short ERROR", cmdCode, 3);
    release_("R7");
    sendFrame(8'h02, 0, 8'h00);
    chk("R7 recovers to START", cmdCode, 0);
    release_("R7");
  endtask

  task automatic tStop();
    sendByte(8'h01);
    sendByte(8'h00);
    @(negedge clk) stopSeen = 1'b1;
    @(negedge clk) stopSeen = 1'b0;
    chk("R10 no frame after stop", frameValid, 0);
    sendFrame(8'h04, 0, 8'h00);
    chk("R10 fresh frame END", cmdCode, 2);
    release_("R10");
  endtask

  task automatic tAddr();
    @(negedge clk) begin addrValid = 1'b1; addrByte = 8'hA0; end
    @(negedge clk) addrValid = 1'b0;
    chk("R9 write addr release", relPulse, 1);
    @(negedge clk) begin addrValid = 1'b1; addrByte = 8'h42; end
    @(negedge clk) addrValid = 1'b0;
    chk("R9 other addr ignored", relPulse, 0);
    @(negedge clk) begin addrValid = 1'b1; addrByte = 8'hA1; end
    @(negedge clk) addrValid = 1'b0;
    chk("R9 read addr leds", ledOn, 3);
    chk("R9 read addr hold", busHold, 1);
    chk("R9 no rel on read", relPulse, 0);
    sendByte(8'h01); sendByte(8'h00); sendByte(8'h02);
    sendByte(8'h02);
    sendByte(8'h02);
    chk("R9 bytes ignored", frameValid, 0);
    chk("R9 no rel while locked", relPulse, 0);
    @(negedge clk) hostRelease = 1'b1;
    @(negedge clk) hostRelease = 1'b0;
    chk("R9 release ignored", busHold, 1);
    chk("R9 leds stay", ledOn, 3);
  endtask

  initial begin
    doReset();
    tReset();
    tStart();
    tWrite();
    tEnd();
    tChecksum();
    tBadCmd();
    tBadSof();
    tBadLen();
    tStop();
    tAddr();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule